// File: doc/BRIEF.md
# NAND Sector Hamming ECC Generator

This block sits beside the 16-bit data port of a NAND flash controller and builds a Hamming-style check code over the bytes that cross that port. A 512-byte sector is treated as two separate 256-byte halves. Each half produces three check bytes: a low line-parity byte, a high line-parity byte and a column-parity byte. The host steers the block by writing 8-bit mode commands. One command clears the accumulators. One starts accumulation. One turns the read port into a result window. One returns the port to plain data transfer.

Each data transfer carries two bytes. The byte in bits 7:0 comes first in sector order and the byte in bits 15:8 follows it. While accumulation is active, both bytes are folded into the parity of the current half. The block moves to the second half on its own after byte 255 and stops taking data after byte 511. In result mode, three successive 16-bit reads return the six check bytes in a fixed interleaved order.

The control state machine has five states. PASS is the plain data mode and the state after reset. CLR_WAIT is entered on the clear command. It waits for one dummy read and then moves to ARMED. ACCUM is entered on the calculate command from any state except CLR_WAIT. RESULT is entered on the result command. The data command leads from any state to PASS, and the clear command leads from any state to CLR_WAIT.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset the block is in PASS, the byte count is zero and all accumulators are clear. A result readout taken straight after reset therefore returns 16'hFFFF for all three words.
- R2: Mode command 8'hF4 clears both halves' accumulators and the byte count, and enters CLR_WAIT from any state.
- R3: In CLR_WAIT, command 8'hB4 is ignored until one read strobe has been accepted. That read moves the block to ARMED, and a later 8'hB4 enters ACCUM.
- R4: In ACCUM, each transfer strobe adds two bytes: bits 7:0 at the current even index and bits 15:8 at the next index. In every other state, transfer strobes change nothing.
- R5: Line parity of a half has 16 bits. For byte index bit k (0..7), bit 2k+1 accumulates the XOR of the bytes' overall parity over bytes whose index bit k is 1. Bit 2k does the same over bytes whose index bit k is 0. Bits 7:0 form the low byte and bits 15:8 the high byte. Both are returned inverted, so an erased (all-8'hFF) half reads 8'hFF.
- R6: The column-parity byte carries, inverted in bits 7:2, CP5..CP0. CP0 is the XOR of even data bits. CP1 is the XOR of odd data bits. CP2 covers bits {0,1,4,5} and CP3 covers bits {2,3,6,7}. CP4 is the low nibble and CP5 the high nibble. Bits 1:0 always read 2'b11.
- R7: Bytes 0..255 go to the first half and bytes 256..511 to the second. Once 512 bytes have been taken, further transfers are ignored until the next 8'hF4.
- R8: Command 8'hD4 enters RESULT with the first word selected. Word 0 is {low LP of half 0, high LP of half 0}. Word 1 is {low LP of half 1, CP byte of half 0}. Word 2 is {CP byte of half 1, high LP of half 1}. In each pair the first-named byte sits in bits 15:8.
- R9: In RESULT, each read strobe advances to the next word, and the word after word 2 is word 0. Outside RESULT, rd_data is 16'h0000.
- R10: Command 8'h94 enters PASS. Any other mode value leaves the state unchanged. In a cycle with mode_wr high, the transfer and read strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode command write strobe |
| mode_val | input | 8 | Mode command value |
| xfer_valid | input | 1 | One 16-bit data transfer on the NAND port this cycle |
| xfer_word | input | 16 | Transferred data, first byte in bits 7:0 |
| rd_strobe | input | 1 | Data-port read strobe |
| rd_data | output | 16 | Check-code word in RESULT, zero otherwise |

## Verification
The bench builds the block with its defaults: 256-byte halves and two halves per sector. With these values the half switch after 128 transfers and the stop after 256 transfers can both be reached in a few hundred cycles. Erased halves, single set bits placed at chosen byte indexes and pseudo-random sector data are all fed through in full. The same values also let the bench drive past the sector end and issue commands out of order to exercise the dummy-read rule.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int unsigned ECC_HALF_BYTES = 256;
    localparam int unsigned ECC_IDX_W      = 8;
    localparam int unsigned ECC_CP_W       = 6;

    localparam logic [7:0] CMD_ECC_CLEAR  = 8'hF4;
    localparam logic [7:0] CMD_ECC_CALC   = 8'hB4;
    localparam logic [7:0] CMD_ECC_RESULT = 8'hD4;
    localparam logic [7:0] CMD_DATA       = 8'h94;

    typedef enum logic [2:0] {
        ST_PASS,
        ST_CLR_WAIT,
        ST_ARMED,
        ST_ACCUM,
        ST_RESULT
    } ecc_state_e;

    // Line-parity contribution of one byte at a given index within its half.
    function automatic logic [2*ECC_IDX_W-1:0] line_term(
        input logic [7:0]           b,
        input logic [ECC_IDX_W-1:0] idx
    );
        logic p;
        logic [2*ECC_IDX_W-1:0] t;
        p = ^b;
        for (int k = 0; k < ECC_IDX_W; k++) begin
            t[2*k+1] = p & idx[k];
            t[2*k]   = p & ~idx[k];
        end
        return t;
    endfunction

    // Column-parity contribution of one byte, CP5..CP0.
    function automatic logic [ECC_CP_W-1:0] col_term(input logic [7:0] b);
        logic [ECC_CP_W-1:0] c;
        c[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
        c[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
        c[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
        c[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
        c[4] = ^b[3:0];
        c[5] = ^b[7:4];
        return c;
    endfunction

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
    import nand_ecc_pkg::*;
#(
    parameter int unsigned SECTOR_BYTES = 512,
    parameter int unsigned CNT_W        = $clog2(SECTOR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [7:0]       mode_val,
    input  logic             xfer_valid,
    input  logic             rd_strobe,
    output ecc_state_e       state_q,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [1:0]       rd_ptr,
    output logic             acc_clr,
    output logic             acc_en
);

    ecc_state_e state_d;
    logic       ptr_step;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            unique case (mode_val)
                CMD_ECC_CLEAR:  state_d = ST_CLR_WAIT;
                CMD_ECC_CALC:   if (state_q != ST_CLR_WAIT) state_d = ST_ACCUM;
                CMD_ECC_RESULT: state_d = ST_RESULT;
                CMD_DATA:       state_d = ST_PASS;
                default:        state_d = state_q;
            endcase
        end else if (state_q == ST_CLR_WAIT && rd_strobe) begin
            state_d = ST_ARMED;
        end
    end

    // Outputs per state
    always_comb begin
        acc_en   = 1'b0;
        ptr_step = 1'b0;
        acc_clr  = mode_wr && (mode_val == CMD_ECC_CLEAR);
        unique case (state_q)
            ST_ACCUM:  acc_en   = !mode_wr && xfer_valid && (byte_cnt < CNT_W'(SECTOR_BYTES));
            ST_RESULT: ptr_step = !mode_wr && rd_strobe;
            ST_PASS, ST_CLR_WAIT, ST_ARMED: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || acc_clr) byte_cnt <= '0;
        else if (acc_en)       byte_cnt <= byte_cnt + CNT_W'(2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                         rd_ptr <= 2'd0;
        else if (mode_wr && mode_val == CMD_ECC_RESULT)     rd_ptr <= 2'd0;
        else if (ptr_step)                                  rd_ptr <= (rd_ptr == 2'd2) ? 2'd0 : rd_ptr + 2'd1;
    end

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int unsigned HALVES = 2,
    parameter int unsigned IDX_W  = ECC_IDX_W,
    parameter int unsigned LP_W   = 2 * IDX_W,
    parameter int unsigned CP_W   = ECC_CP_W,
    parameter int unsigned HSEL_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          en,
    input  logic [HSEL_W-1:0]             half_sel,
    input  logic [IDX_W-1:0]              idx_even,
    input  logic [15:0]                   word,
    output logic [HALVES-1:0][LP_W-1:0]   lp_q,
    output logic [HALVES-1:0][CP_W-1:0]   cp_q
);

    logic [LP_W-1:0] lp_term;
    logic [CP_W-1:0] cp_term;

    always_comb begin
        lp_term = line_term(word[7:0], idx_even) ^ line_term(word[15:8], idx_even | IDX_W'(1));
        cp_term = col_term(word[7:0]) ^ col_term(word[15:8]);
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [LP_W-1:0] lp_r;
        logic [CP_W-1:0] cp_r;
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lp_r <= '0;
                cp_r <= '0;
            end else if (en && half_sel == HSEL_W'(h)) begin
                lp_r <= lp_r ^ lp_term;
                cp_r <= cp_r ^ cp_term;
            end
        end
        assign lp_q[h] = lp_r;
        assign cp_q[h] = cp_r;
    end

endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout
    import nand_ecc_pkg::*;
#(
    parameter int unsigned LP_W = 2 * ECC_IDX_W,
    parameter int unsigned CP_W = ECC_CP_W
) (
    input  logic                   active,
    input  logic [1:0]             ptr,
    input  logic [1:0][LP_W-1:0]   lp,
    input  logic [1:0][CP_W-1:0]   cp,
    output logic [15:0]            rd_data
);

    logic [1:0][7:0] lp_lo, lp_hi, cp_b;

    always_comb begin
        for (int h = 0; h < 2; h++) begin
            lp_lo[h] = ~lp[h][7:0];
            lp_hi[h] = ~lp[h][15:8];
            cp_b[h]  = {~cp[h], 2'b11};
        end
        rd_data = 16'h0000;
        if (active) begin
            unique case (ptr)
                2'd0:    rd_data = {lp_lo[0], lp_hi[0]};
                2'd1:    rd_data = {lp_lo[1], cp_b[0]};
                2'd2:    rd_data = {cp_b[1],  lp_hi[1]};
                default: rd_data = 16'h0000;
            endcase
        end
    end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int unsigned HALF_BYTES = ECC_HALF_BYTES,
    parameter int unsigned HALVES     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wr,
    input  logic [7:0]  mode_val,
    input  logic        xfer_valid,
    input  logic [15:0] xfer_word,
    input  logic        rd_strobe,
    output logic [15:0] rd_data
);

    localparam int unsigned SECTOR_BYTES = HALF_BYTES * HALVES;
    localparam int unsigned IDX_W        = $clog2(HALF_BYTES);
    localparam int unsigned HSEL_W       = (HALVES > 1) ? $clog2(HALVES) : 1;
    localparam int unsigned CNT_W        = $clog2(SECTOR_BYTES + 1);
    localparam int unsigned LP_W         = 2 * IDX_W;

    ecc_state_e                  state_q;
    logic [CNT_W-1:0]            byte_cnt;
    logic [1:0]                  rd_ptr;
    logic                        acc_clr, acc_en;
    logic [HALVES-1:0][LP_W-1:0] lp_q;
    logic [HALVES-1:0][ECC_CP_W-1:0] cp_q;

    nand_ecc_ctrl #(.SECTOR_BYTES(SECTOR_BYTES), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
        .xfer_valid(xfer_valid), .rd_strobe(rd_strobe), .state_q(state_q),
        .byte_cnt(byte_cnt), .rd_ptr(rd_ptr), .acc_clr(acc_clr), .acc_en(acc_en)
    );

    nand_ecc_accum #(.HALVES(HALVES), .IDX_W(IDX_W), .LP_W(LP_W),
                     .CP_W(ECC_CP_W), .HSEL_W(HSEL_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en),
        .half_sel(byte_cnt[IDX_W +: HSEL_W]), .idx_even(byte_cnt[IDX_W-1:0]),
        .word(xfer_word), .lp_q(lp_q), .cp_q(cp_q)
    );

    nand_ecc_readout #(.LP_W(LP_W), .CP_W(ECC_CP_W)) u_readout (
        .active(state_q == ST_RESULT), .ptr(rd_ptr),
        .lp(lp_q[1:0]), .cp(cp_q[1:0]), .rd_data(rd_data)
    );

endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk
    import nand_ecc_pkg::*;
#(
    parameter int unsigned SECTOR_BYTES = 512,
    parameter int unsigned CNT_W        = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic [7:0]       mode_val,
    input logic             rd_strobe,
    input logic [15:0]      rd_data,
    input ecc_state_e       state_q,
    input logic [CNT_W-1:0] byte_cnt,
    input logic [1:0]       rd_ptr
);

    assert_clear_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_val == CMD_ECC_CLEAR) |=> (byte_cnt == '0 && state_q == ST_CLR_WAIT));

    assert_dummy_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_val == CMD_ECC_CALC && state_q == ST_CLR_WAIT) |=> state_q == ST_CLR_WAIT);

    assert_byte_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt[0] == 1'b0);

    assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(SECTOR_BYTES));

    assert_hold_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == CNT_W'(SECTOR_BYTES) && !mode_wr) |=> byte_cnt == CNT_W'(SECTOR_BYTES));

    assert_result_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_val == CMD_ECC_RESULT) |=> (state_q == ST_RESULT && rd_ptr == 2'd0));

    assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESULT && rd_ptr == 2'd2 && rd_strobe && !mode_wr) |=> rd_ptr == 2'd0);

    assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr != 2'd3);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RESULT) |-> rd_data == 16'h0000);

    assert_data_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_val == CMD_DATA) |=> state_q == ST_PASS);

endmodule

bind nand_ecc_gen nand_ecc_chk #(.SECTOR_BYTES(SECTOR_BYTES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .state_q(state_q),
    .byte_cnt(byte_cnt), .rd_ptr(rd_ptr)
);

// File: tb/tb_nand_ecc_gen.sv
module tb_nand_ecc_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_val = 8'h00;
    logic        xfer_valid = 1'b0;
    logic [15:0] xfer_word = 16'h0000;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    // Reference model: 0 pass, 1 clear-wait, 2 armed, 3 accum, 4 result
    int       m_state = 0;
    int       m_cnt   = 0;
    int       m_ptr   = 0;
    bit [15:0] m_lp [2];
    bit [5:0]  m_cp [2];
    int unsigned lfsr = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc_gen dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
        .xfer_valid(xfer_valid), .xfer_word(xfer_word), .rd_strobe(rd_strobe),
        .rd_data(rd_data)
    );

    function automatic bit [15:0] model_word();
        bit [7:0] lo0, hi0, lo1, hi1, c0, c1;
        if (m_state != 4) return 16'h0000;
        lo0 = ~m_lp[0][7:0];  hi0 = ~m_lp[0][15:8];
        lo1 = ~m_lp[1][7:0];  hi1 = ~m_lp[1][15:8];
        c0  = {~m_cp[0], 2'b11};
        c1  = {~m_cp[1], 2'b11};
        case (m_ptr)
            0: return {lo0, hi0};
            1: return {lo1, c0};
            default: return {c1, hi1};
        endcase
    endfunction

    task automatic model_byte(input int pos, input bit [7:0] b);
        int h = pos / 256;
        int i = pos % 256;
        bit p = ^b;
        if (p) begin
            for (int k = 0; k < 8; k++) begin
                if ((i >> k) & 1) m_lp[h][2*k+1] ^= 1'b1;
                else              m_lp[h][2*k]   ^= 1'b1;
            end
        end
        m_cp[h][0] ^= b[0] ^ b[2] ^ b[4] ^ b[6];
        m_cp[h][1] ^= b[1] ^ b[3] ^ b[5] ^ b[7];
        m_cp[h][2] ^= b[0] ^ b[1] ^ b[4] ^ b[5];
        m_cp[h][3] ^= b[2] ^ b[3] ^ b[6] ^ b[7];
        m_cp[h][4] ^= ^b[3:0];
        m_cp[h][5] ^= ^b[7:4];
    endtask

    task automatic model_step(input bit mw, input bit [7:0] mv, input bit xv,
                              input bit [15:0] xw, input bit rs);
        if (mw) begin
            case (mv)
                8'hF4: begin
                    m_state = 1; m_cnt = 0;
                    m_lp[0] = '0; m_lp[1] = '0; m_cp[0] = '0; m_cp[1] = '0;
                end
                8'hB4: if (m_state != 1) m_state = 3;
                8'hD4: begin m_state = 4; m_ptr = 0; end
                8'h94: m_state = 0;
                default: ;
            endcase
        end else begin
            if (m_state == 1 && rs) m_state = 2;
            else if (m_state == 4 && rs) m_ptr = (m_ptr + 1) % 3;
            else if (m_state == 3 && xv && m_cnt < 512) begin
                model_byte(m_cnt, xw[7:0]);
                model_byte(m_cnt + 1, xw[15:8]);
                m_cnt += 2;
            end
        end
    endtask

    task automatic compare();
        bit [15:0] exp = model_word();
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h (t=%0t)", cur_req, rd_data, exp, $time);
        end
    endtask

    // One clock: compare the state left by the previous edge, then drive.
    task automatic cyc(input bit mw, input bit [7:0] mv, input bit xv,
                       input bit [15:0] xw, input bit rs);
        @(negedge clk);
        compare();
        mode_wr = mw; mode_val = mv; xfer_valid = xv; xfer_word = xw; rd_strobe = rs;
        model_step(mw, mv, xv, xw, rs);
    endtask

    task automatic cmd(input bit [7:0] v);  cyc(1'b1, v, 1'b0, 16'h0, 1'b0); endtask
    task automatic rd();                    cyc(1'b0, 8'h0, 1'b0, 16'h0, 1'b1); endtask
    task automatic xfer(input bit [15:0] w); cyc(1'b0, 8'h0, 1'b1, w, 1'b0); endtask
    task automatic idle();                  cyc(1'b0, 8'h0, 1'b0, 16'h0, 1'b0); endtask

    task automatic read_all(input int n);
        cmd(8'hD4);
        for (int i = 0; i < n; i++) rd();
        idle();
    endtask

    function automatic bit [15:0] next_rand();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return lfsr[15:0];
    endfunction

    task automatic start_calc();
        cmd(8'hF4); rd(); cmd(8'hB4);
    endtask

    initial begin
        m_lp[0] = '0; m_lp[1] = '0; m_cp[0] = '0; m_cp[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, then readout of untouched accumulators
        cur_req = "R1";
        idle(); idle();
        read_all(3);
        cmd(8'h94);

        // R3: calculate refused before the dummy read; R2 clears
        cur_req = "R3";
        cmd(8'hF4); cmd(8'hB4);
        xfer(16'h1234); xfer(16'h0001);
        read_all(3);
        cur_req = "R2";
        cmd(8'hF4); idle();
        read_all(3);

        // R5/R6: erased first half gives all-ones bytes
        cur_req = "R5";
        start_calc();
        for (int i = 0; i < 128; i++) xfer(16'hFFFF);
        read_all(3);

        // R5/R7: single-byte patterns in each half at chosen indexes
        cur_req = "R7";
        start_calc();
        for (int i = 0; i < 256; i++) begin
            if (i == 18)       xfer(16'h0100);
            else if (i == 228) xfer(16'h5A07);
            else               xfer(16'h0000);
        end
        cur_req = "R9";
        read_all(7);

        // R6: column-only patterns (even byte parity, nonzero columns)
        cur_req = "R6";
        start_calc();
        xfer(16'h0303); xfer(16'hC0F0); xfer(16'h0A00);
        read_all(3);

        // R7/R8: pseudo-random full sector plus overrun transfers
        cur_req = "R8";
        start_calc();
        for (int i = 0; i < 260; i++) xfer(next_rand());
        read_all(4);
        cur_req = "R7";
        xfer(16'hABCD); read_all(3);

        // R4/R10: transfers outside ACCUM, unknown mode, simultaneous strobes
        cur_req = "R4";
        cmd(8'h94); xfer(16'h8001); cmd(8'h55); xfer(16'h0102);
        read_all(3);
        cur_req = "R10";
        start_calc();
        xfer(16'h0001);
        cyc(1'b1, 8'h94, 1'b1, 16'h0100, 1'b1);
        xfer(16'h0700);
        cmd(8'hB4); xfer(16'h0080);
        cmd(8'h55); xfer(16'h2000);
        read_all(3);
        cyc(1'b1, 8'h55, 1'b0, 16'h0, 1'b1);
        rd(); idle();
        cmd(8'h94); idle(); idle();

        @(negedge clk);
        compare();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule